// File: doc/BRIEF.md
# Bitplane Fetch Window Sequencer

This block decides, for every horizontal position of a scanline, whether the current bus slot goes to a bitplane word fetch. If it does, the block also says which plane is served and how many 16-bit words that one slot carries. Fetching is confined to a programmable window of positions. Inside the window, slots are grouped into fixed-length fetch groups. The length of a group follows from the pixel resolution and from the fetch-width mode. The first slots of each group serve the active planes in ascending order.

The block keeps a running count of the slots granted on the current line. At each line start it freezes the previous line's total so that bus budgeting logic can read it. It also holds the low address bits of every plane pointer and flags each active plane whose pointer breaks the alignment that the selected fetch width needs. Pixel shifting, display clipping and the memory access itself are handled elsewhere.

Top module: `bitplane_fetch_seq`

## Requirements
- R1: A grant is issued only for a position `hpos` with `fetch_en`=1 and `win_start` <= `hpos` <= `win_stop`. No grant occurs before the start position or after the stop position, and none occurs while `fetch_en`=0.
- R2: The grant outputs for a position appear one clock after that position is presented. Grant outputs are `fetch_vld`, `fetch_plane` and `fetch_words`.
- R3: The group length in slots is base × multiplier. The base is 8, 4 or 2 for `res` 00 (low), 01 (high) and 10 or 11 (super). The phase of a slot is (`hpos` − `win_start`) mod the group length. A slot whose phase is below the effective depth is granted, and its plane index equals its phase, so planes go 0,1,2,… in every group.
- R4: The effective depth is `depth` clamped to 8 and then to the group length. A `depth` of 0 produces no grants.
- R5: `width_mode` sets the multiplier and words per slot: 00 gives 1, 01 and 10 give 2, and 11 gives 4. Each grant occupies exactly one slot, and `fetch_words` reports that count. `fetch_words` is 0 when there is no grant.
- R6: A `line_start` cycle loads `slot_cnt` with that cycle's grant (0 or 1) and copies the old `slot_cnt` to `line_slots`. In every other cycle `slot_cnt` adds 1 per grant.
- R7: A window that is a whole number of groups long yields window/group × effective depth slots per line. For example, low resolution with 8 planes at multiplier 4 over 160 positions gives 40.
- R8: When the stop position cuts a group short, only the slots up to and including the stop position are granted.
- R9: A write stores `ptr_low`, the low three byte-address bits, for plane `ptr_plane`. `misalign[p]` is 1 when plane p < effective depth and its stored bits are not a multiple of 2, 4 or 8 bytes for multiplier 1, 2 or 4. The flags follow the current mode without a rewrite.
- R10: After reset all outputs are 0 and all stored pointer bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one slot per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | First position of a new line |
| hpos | input | HPW | Horizontal slot position |
| fetch_en | input | 1 | Bitplane fetch enable |
| win_start | input | HPW | First position of the fetch window |
| win_stop | input | HPW | Last position of the fetch window |
| depth | input | 4 | Number of planes requested |
| res | input | 2 | Resolution code |
| width_mode | input | 2 | Fetch-width code |
| ptr_wr | input | 1 | Store pointer low bits |
| ptr_plane | input | 3 | Plane whose pointer is written |
| ptr_low | input | 3 | Low three byte-address bits of that pointer |
| fetch_vld | output | 1 | Slot granted to a bitplane fetch |
| fetch_plane | output | 3 | Plane served by the grant |
| fetch_words | output | 3 | Words moved by the grant |
| slot_cnt | output | CW | Grants so far on this line |
| line_slots | output | CW | Grant total of the previous line |
| misalign | output | 8 | Per-plane alignment error flags |

## Verification
Two functions can fall in the same cycle: a grant and the line-start clear of the slot counter. If they coincide, the counter must restart at 1 rather than 0, and the old total must still be latched whole. The bench provokes this by opening a window at position 0, so that plane 0 is granted exactly on the line-start cycle. It then judges `slot_cnt` and `line_slots` on the following edge against its own per-position tally.

// File: rtl/bfs_pkg.sv
package bfs_pkg;

  localparam int MAX_PLANES = 8;

  // log2 of the group base length: low 8, high 4, super 2
  function automatic logic [2:0] res_shift(input logic [1:0] res);
    case (res)
      2'b00:   return 3'd3;
      2'b01:   return 3'd2;
      default: return 3'd1;
    endcase
  endfunction

  // log2 of words per slot: 00 -> 1, 01/10 -> 2, 11 -> 4
  function automatic logic [1:0] wide_shift(input logic [1:0] wm);
    case (wm)
      2'b00:   return 2'd0;
      2'b11:   return 2'd2;
      default: return 2'd1;
    endcase
  endfunction

  function automatic logic [5:0] group_len(input logic [1:0] res, input logic [1:0] wm);
    logic [2:0] sh;
    sh = res_shift(res) + {1'b0, wide_shift(wm)};
    return 6'd1 << sh;
  endfunction

  function automatic logic [2:0] words_per_slot(input logic [1:0] wm);
    return 3'd1 << wide_shift(wm);
  endfunction

  // byte-offset bits that must be zero for the fetch width
  function automatic logic [2:0] align_mask(input logic [1:0] wm);
    case (wide_shift(wm))
      2'd0:    return 3'b001;
      2'd1:    return 3'b011;
      default: return 3'b111;
    endcase
  endfunction

  function automatic logic [5:0] eff_depth(input logic [3:0] depth, input logic [5:0] glen);
    logic [5:0] d;
    d = (depth > 4'd8) ? 6'd8 : {2'b00, depth};
    return (d > glen) ? glen : d;
  endfunction

endpackage

// File: rtl/bfs_window.sv
module bfs_window #(
  parameter int HPW = 9
) (
  input  logic [HPW-1:0] hpos,
  input  logic [HPW-1:0] win_start,
  input  logic [HPW-1:0] win_stop,
  input  logic           fetch_en,
  input  logic [5:0]     glen,
  input  logic [5:0]     edepth,
  output logic           hit,
  output logic [2:0]     plane
);
  logic           in_win;
  logic [HPW-1:0] offs;
  logic [5:0]     gmask;
  logic [HPW-1:0] phase;

  // window is inclusive at both ends; one slot off shifts the image
  assign in_win = fetch_en && (hpos >= win_start) && (hpos <= win_stop);
  assign offs   = hpos - win_start;
  // group length is a power of two, so the phase is a mask
  assign gmask  = glen - 6'd1;
  assign phase  = offs & HPW'(gmask);
  assign hit    = in_win && (phase < HPW'(edepth));
  assign plane  = phase[2:0];
endmodule

// File: rtl/bfs_slot_counter.sv
module bfs_slot_counter #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_start,
  input  logic          hit,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] total
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      total <= '0;
    end else if (line_start) begin
      total <= cnt;
      cnt   <= CW'(hit);
    end else if (hit) begin
      cnt <= cnt + CW'(1);
    end
  end

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> (cnt <= CW'(1)));
  p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !line_start |=> ((cnt == $past(cnt)) || (cnt == $past(cnt) + CW'(1))));
endmodule

// File: rtl/bfs_align_check.sv
module bfs_align_check import bfs_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ptr_wr,
  input  logic [2:0] ptr_plane,
  input  logic [2:0] ptr_low,
  input  logic [1:0] width_mode,
  input  logic [5:0] edepth,
  output logic [MAX_PLANES-1:0] flags
);
  logic [2:0] amask;
  logic [2:0] lo_q [MAX_PLANES];

  assign amask = align_mask(width_mode);

  for (genvar i = 0; i < MAX_PLANES; i++) begin : g_plane
    always_ff @(posedge clk) begin
      if (!rst_n)                            lo_q[i] <= '0;
      else if (ptr_wr && ptr_plane == 3'(i)) lo_q[i] <= ptr_low;
    end
    assign flags[i] = ((lo_q[i] & amask) != 3'd0) && (6'(i) < edepth);
  end

  p_clean_ptr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_wr && ptr_low == 3'd0) |=> !flags[$past(ptr_plane)]);
endmodule

// File: rtl/bitplane_fetch_seq.sv
module bitplane_fetch_seq import bfs_pkg::*; #(
  parameter int HPW = 9,
  parameter int CW  = HPW + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           line_start,
  input  logic [HPW-1:0] hpos,
  input  logic           fetch_en,
  input  logic [HPW-1:0] win_start,
  input  logic [HPW-1:0] win_stop,
  input  logic [3:0]     depth,
  input  logic [1:0]     res,
  input  logic [1:0]     width_mode,
  input  logic           ptr_wr,
  input  logic [2:0]     ptr_plane,
  input  logic [2:0]     ptr_low,
  output logic           fetch_vld,
  output logic [2:0]     fetch_plane,
  output logic [2:0]     fetch_words,
  output logic [CW-1:0]  slot_cnt,
  output logic [CW-1:0]  line_slots,
  output logic [7:0]     misalign
);
  logic       hit;
  logic [2:0] plane_c;
  logic [5:0] glen;
  logic [5:0] edepth;

  assign glen   = group_len(res, width_mode);
  assign edepth = eff_depth(depth, glen);

  bfs_window #(.HPW(HPW)) u_win (
    .hpos(hpos), .win_start(win_start), .win_stop(win_stop),
    .fetch_en(fetch_en), .glen(glen), .edepth(edepth),
    .hit(hit), .plane(plane_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fetch_vld   <= 1'b0;
      fetch_plane <= '0;
      fetch_words <= '0;
    end else begin
      fetch_vld   <= hit;
      fetch_plane <= hit ? plane_c : 3'd0;
      fetch_words <= hit ? words_per_slot(width_mode) : 3'd0;
    end
  end

  bfs_slot_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .hit(hit),
    .cnt(slot_cnt), .total(line_slots)
  );

  bfs_align_check u_align (
    .clk(clk), .rst_n(rst_n), .ptr_wr(ptr_wr), .ptr_plane(ptr_plane),
    .ptr_low(ptr_low), .width_mode(width_mode), .edepth(edepth),
    .flags(misalign)
  );

  p_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_vld |-> ($past(fetch_en) && $past(hpos) >= $past(win_start)
                   && $past(hpos) <= $past(win_stop)));
  p_one_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_vld |-> ($countones(fetch_words) == 1));
  p_idle_words_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_vld |-> (fetch_words == 3'd0));
  p_plane_depth_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_vld |-> ({1'b0, fetch_plane} < $past(depth)));
endmodule

// File: tb/bitplane_fetch_seq_bench.sv
module bitplane_fetch_seq_bench;
  localparam int HPW  = 9;
  localparam int CW   = HPW + 1;
  localparam int LINE = 228;

  logic clk = 0, rst_n = 0, line_start = 0, fetch_en = 0, ptr_wr = 0;
  logic [HPW-1:0] hpos = '0, win_start = '0, win_stop = '0;
  logic [3:0] depth = '0;
  logic [1:0] res = '0, width_mode = '0;
  logic [2:0] ptr_plane = '0, ptr_low = '0;
  logic fetch_vld;
  logic [2:0] fetch_plane, fetch_words;
  logic [CW-1:0] slot_cnt, line_slots;
  logic [7:0] misalign;

  int total = 0, bad = 0;
  int stored_lo [8];

  always #5 clk = ~clk;

  bitplane_fetch_seq #(.HPW(HPW)) u_bitplane_fetch_seq (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int grp(input int r, input int w);
    int b = (r == 0) ? 8 : (r == 1) ? 4 : 2;
    int m = (w == 0) ? 1 : (w == 3) ? 4 : 2;
    return b * m;
  endfunction

  function automatic int edep(input int d, input int g);
    int e = (d > 8) ? 8 : d;
    return (e > g) ? g : e;
  endfunction

  task automatic step(input int h, input bit ls);
    hpos = HPW'(h);
    line_start = ls;
    @(posedge clk); #1;
  endtask

  // run one full line, compare every position, then check totals
  task automatic run_line(input int en, input int st, input int sp, input int d,
                          input int r, input int w, input int exp_total, input string req);
    int g, e, cnt, m;
    fetch_en = en[0]; win_start = HPW'(st); win_stop = HPW'(sp);
    depth = 4'(d); res = 2'(r); width_mode = 2'(w);
    g = grp(r, w); e = edep(d, g);
    m = (w == 0) ? 1 : (w == 3) ? 4 : 2;
    cnt = 0;
    for (int h = 0; h < LINE; h++) begin
      bit hv;
      int ph;
      ph = (h - st) % g;
      hv = (en != 0) && h >= st && h <= sp && ph < e;
      step(h, h == 0);
      cnt = (h == 0) ? int'(hv) : cnt + int'(hv);
      if (fetch_vld !== hv) chk(0, {req, " R1 R2 R3 grant"}, fetch_vld, hv);
      if (hv && fetch_plane !== 3'(ph)) chk(0, {req, " R3 plane"}, fetch_plane, ph);
      if (fetch_words !== (hv ? 3'(m) : 3'd0)) chk(0, {req, " R5 words"}, fetch_words, hv ? m : 0);
      if (slot_cnt !== CW'(cnt)) chk(0, {req, " R6 running"}, slot_cnt, cnt);
    end
    chk(1, {req, " per-position scan"}, 0, 0);
    chk(cnt == exp_total, {req, " R7 bench tally"}, cnt, exp_total);
    step(0, 1);
    chk(line_slots == CW'(exp_total), {req, " R6 R7 line total"}, line_slots, exp_total);
  endtask

  task automatic wr_ptr(input int p, input int lo);
    ptr_wr = 1; ptr_plane = 3'(p); ptr_low = 3'(lo);
    @(posedge clk); #1;
    ptr_wr = 0;
    stored_lo[p] = lo;
  endtask

  task automatic chk_align(input int d, input int w, input string req);
    int exp = 0, a;
    depth = 4'(d); width_mode = 2'(w); res = 2'b00;
    a = (w == 0) ? 2 : (w == 3) ? 8 : 4;
    for (int p = 0; p < 8; p++)
      if (p < edep(d, grp(0, w)) && (stored_lo[p] % a) != 0) exp |= (1 << p);
    #1;
    chk(misalign == 8'(exp), req, misalign, exp);
  endtask

  task automatic t_reset;
    chk(fetch_vld == 0 && fetch_words == 0 && fetch_plane == 0, "R10 grant outputs", fetch_vld, 0);
    chk(slot_cnt == 0 && line_slots == 0, "R10 counters", slot_cnt, 0);
    depth = 4'd8; width_mode = 2'b11; #1;
    chk(misalign == 0, "R10 pointers cleared", misalign, 0);
  endtask

  task automatic t_coincide;
    int c;
    // window opens at 0: plane 0 granted on the line-start cycle
    run_line(1, 0, 15, 2, 0, 0, 4, "coincide");
    c = slot_cnt;
    chk(c == 1, "R6 clear with grant", c, 1);
  endtask

  task automatic t_align;
    int lo [8] = '{0, 1, 2, 4, 6, 3, 7, 5};
    for (int p = 0; p < 8; p++) wr_ptr(p, lo[p]);
    chk_align(8, 0, "R9 align x1");
    chk_align(8, 1, "R9 align x2");
    chk_align(8, 2, "R9 align x2 alt code");
    chk_align(8, 3, "R9 align x4");
    chk_align(3, 3, "R9 inactive planes unflagged");
    wr_ptr(5, 0);
    chk_align(8, 3, "R9 rewrite clears");
  endtask

  initial begin
    #(200000 * 10);
    chk(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    run_line(1, 56, 215, 4, 0, 0, 80,  "lo d4 x1");
    run_line(1, 56, 215, 4, 1, 0, 160, "hi d4 x1");
    run_line(1, 56, 215, 8, 0, 3, 40,  "lo d8 x4");
    run_line(1, 56, 215, 2, 2, 1, 80,  "super d2 x2");
    run_line(1, 56, 215, 6, 0, 2, 60,  "lo d6 code10");
    run_line(0, 56, 215, 4, 0, 0, 0,   "R1 disabled");
    run_line(1, 56, 215, 0, 0, 0, 0,   "R4 depth zero");
    run_line(1, 56, 215, 8, 1, 0, 160, "R4 depth clamp");
    run_line(1, 56, 60,  8, 0, 0, 5,   "R8 truncated");
    run_line(1, 57, 57,  3, 0, 0, 1,   "R1 single slot");
    t_coincide();
    t_align();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule